// File: doc/BRIEF.md
# Four-Channel Serial Card Register Front End

This block is the bus-facing register decoder of a plug-in card carrying four serial channels. It watches a 16-bit address inside a fixed I/O window whose upper byte is 0xF2. A 4-bit card number in address bits [7:4] picks one card out of as many as sixteen on the same bus. The low nibble then selects a register. Eight of the sixteen offsets give each channel a status/control location and a data location. The other eight are card-wide command and configuration registers.

The host bus is asynchronous. The host raises a read or write strobe and holds it. The card synchronises the strobe and raises an address pre-empt line. On a read it drives the selected byte, and on a write it captures the byte. It then raises data-ready. Both lines stay high until the host lets go of its strobe. The channels see single-cycle strobes that come out with the pre-empt rise. The card also issues single-cycle command pulses for interrupt on, interrupt off, software transmit interrupt and card reset. The channels and interrupt arbitration live elsewhere.

Top module: `qcr_regfront`

## Requirements
- R1: A bus cycle is accepted only when addr[15:8] is 0xF2 and addr[7:4] equals card_id. For any other address, apre, drdy and dbus_oe stay low and no strobe or pulse is issued.
- R2: apre rises in the third clock cycle after a strobe rises, and drdy rises one cycle later. Both stay high while the strobe is held. Both fall in the third cycle after the strobe falls.
- R3: A read of offset 2p returns status byte p (ch_stat_i[8p+7:8p]). A read of offset 2p+1 returns receive byte p (ch_rx_i[8p+7:8p]), for p in 0..3. The value is on dbus_out while drdy is high.
- R4: A read of offset 2p+1 gives exactly one single-cycle pulse on rx_rd_stb[p], in the cycle apre rises.
- R5: A write of offset 2p pulses ctl_wr_stb[p] once, and a write of offset 2p+1 pulses tx_wr_stb[p] once, in the cycle apre rises. wr_byte holds the written byte from that cycle on.
- R6: A write of offset 8 loads rts_mask from data bits [3:0]. Offset 0xA loads irq_level from bits [3:0]. Offset 0xB loads the whole byte into baud_div.
- R7: Writes of offsets 0xC, 0xD and 0xE each give one single-cycle pulse, on swtx_irq, irq_off and irq_on respectively, in the cycle apre rises.
- R8: A write of offset 0xF pulses chan_rst for one cycle and clears rts_mask and irq_level. It leaves baud_div unchanged.
- R9: Reads of offsets 8 to 0xF return 0x00 and still complete the handshake. A write of offset 9 changes no register and gives no pulse.
- R10: dbus_oe is high only during an accepted read cycle. It is low for writes and returns low, with dbus_out at 0x00, when apre falls.
- R11: After reset, every output is low except baud_div, which holds DIV_INIT (0xFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| card_id | input | 4 | Card number compared with addr[7:4] |
| addr | input | 16 | Host address |
| dbus_in | input | 8 | Host write data |
| rd_req | input | 1 | Asynchronous read strobe, active high |
| wr_req | input | 1 | Asynchronous write strobe, active high |
| ch_stat_i | input | 32 | Status byte of each channel, channel p in bits [8p+7:8p] |
| ch_rx_i | input | 32 | Receive byte of each channel, same packing |
| dbus_out | output | 8 | Read data to host |
| dbus_oe | output | 1 | Drive enable for dbus_out |
| apre | output | 1 | Address pre-empt |
| drdy | output | 1 | Data ready |
| ctl_wr_stb | output | 4 | Per-channel control write strobe |
| tx_wr_stb | output | 4 | Per-channel transmit data write strobe |
| rx_rd_stb | output | 4 | Per-channel receive data read strobe |
| wr_byte | output | 8 | Last byte written by the host |
| rts_mask | output | 4 | Channels using RTS flow control |
| irq_level | output | 4 | Interrupt level |
| baud_div | output | 8 | Baud generator divisor |
| swtx_irq | output | 1 | Software transmit interrupt pulse |
| irq_off | output | 1 | Interrupt disable pulse |
| irq_on | output | 1 | Interrupt enable pulse |
| chan_rst | output | 1 | Card and channel reset pulse |

## Verification
Every result follows a fixed cycle count from the strobe edge. Two synchroniser flops and one edge flop put the apre rise, the strobes and the command pulses at the third clock after the strobe goes up. drdy and the read byte follow in the fourth. The release comes at the third clock after the strobe drops. Each scenario task drives its strobe on a falling clock edge and samples on later falling edges at exactly those counts. It checks that apre is still low one cycle early and still high one cycle before release, so an extra or a missing register stage is caught.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int OFF_W     = 4;

  localparam logic [OFF_W-1:0] OFF_RTS  = 4'h8;
  localparam logic [OFF_W-1:0] OFF_LVL  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_DIV  = 4'hB;
  localparam logic [OFF_W-1:0] OFF_SWTX = 4'hC;
  localparam logic [OFF_W-1:0] OFF_IOFF = 4'hD;
  localparam logic [OFF_W-1:0] OFF_ION  = 4'hE;
  localparam logic [OFF_W-1:0] OFF_RST  = 4'hF;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_RDY} hs_state_e;

  typedef struct packed {
    logic              hit;
    logic              port_sel;
    logic [PORT_W-1:0] port;
    logic              is_data;
    logic [OFF_W-1:0]  off;
  } dec_t;
endpackage

// File: rtl/qcr_sync.sv
module qcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/qcr_decode.sv
module qcr_decode
  import qcr_pkg::*;
#(
  parameter logic [7:0] WIN_HI = 8'hF2
) (
  input  logic [15:0] addr,
  input  logic [3:0]  card_id,
  output dec_t        dec
);
  localparam int PORT_SPAN = 2 * NUM_PORTS;

  always_comb begin
    dec          = '0;
    dec.hit      = (addr[15:8] == WIN_HI) && (addr[7:4] == card_id);
    dec.off      = addr[OFF_W-1:0];
    dec.port_sel = (int'(addr[OFF_W-1:0]) < PORT_SPAN);
    dec.port     = addr[PORT_W:1];
    dec.is_data  = addr[0];
  end
endmodule

// File: rtl/qcr_cardregs.sv
module qcr_cardregs
  import qcr_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         LVL_W    = 4,
  parameter logic [7:0] DIV_INIT = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     off,
  input  logic [DW-1:0]        wdata,
  output logic [NUM_PORTS-1:0] rts_mask,
  output logic [LVL_W-1:0]     irq_level,
  output logic [DW-1:0]        baud_div,
  output logic                 swtx_irq,
  output logic                 irq_off,
  output logic                 irq_on,
  output logic                 chan_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rts_mask  <= '0;
      irq_level <= '0;
      baud_div  <= DW'(DIV_INIT);
      swtx_irq  <= 1'b0;
      irq_off   <= 1'b0;
      irq_on    <= 1'b0;
      chan_rst  <= 1'b0;
    end else begin
      swtx_irq <= 1'b0;
      irq_off  <= 1'b0;
      irq_on   <= 1'b0;
      chan_rst <= 1'b0;
      if (wr_en) begin
        case (off)
          OFF_RTS:  rts_mask  <= wdata[NUM_PORTS-1:0];
          OFF_LVL:  irq_level <= wdata[LVL_W-1:0];
          OFF_DIV:  baud_div  <= wdata;
          OFF_SWTX: swtx_irq  <= 1'b1;
          OFF_IOFF: irq_off   <= 1'b1;
          OFF_ION:  irq_on    <= 1'b1;
          OFF_RST: begin
            chan_rst  <= 1'b1;
            rts_mask  <= '0;
            irq_level <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qcr_regfront.sv
module qcr_regfront
  import qcr_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         LVL_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] WIN_HI      = 8'hF2,
  parameter logic [7:0] DIV_INIT    = 8'hFE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              card_id,
  input  logic [15:0]             addr,
  input  logic [DW-1:0]           dbus_in,
  input  logic                    rd_req,
  input  logic                    wr_req,
  input  logic [NUM_PORTS*DW-1:0] ch_stat_i,
  input  logic [NUM_PORTS*DW-1:0] ch_rx_i,
  output logic [DW-1:0]           dbus_out,
  output logic                    dbus_oe,
  output logic                    apre,
  output logic                    drdy,
  output logic [NUM_PORTS-1:0]    ctl_wr_stb,
  output logic [NUM_PORTS-1:0]    tx_wr_stb,
  output logic [NUM_PORTS-1:0]    rx_rd_stb,
  output logic [DW-1:0]           wr_byte,
  output logic [NUM_PORTS-1:0]    rts_mask,
  output logic [LVL_W-1:0]        irq_level,
  output logic [DW-1:0]           baud_div,
  output logic                    swtx_irq,
  output logic                    irq_off,
  output logic                    irq_on,
  output logic                    chan_rst
);
  logic rd_lvl, rd_rise, rd_fall_unused;
  logic wr_lvl, wr_rise, wr_fall_unused;
  dec_t dec;
  hs_state_e state;
  logic cyc_rd;
  logic start, start_rd, start_wr, held;
  logic [DW-1:0] rd_mux;
  logic [NUM_PORTS-1:0] port_hot;

  qcr_sync #(.STAGES(SYNC_STAGES)) i_rd_sync (
    .clk(clk), .rst(rst), .d(rd_req),
    .lvl(rd_lvl), .rise(rd_rise), .fall(rd_fall_unused)
  );

  qcr_sync #(.STAGES(SYNC_STAGES)) i_wr_sync (
    .clk(clk), .rst(rst), .d(wr_req),
    .lvl(wr_lvl), .rise(wr_rise), .fall(wr_fall_unused)
  );

  qcr_decode #(.WIN_HI(WIN_HI)) i_dec (
    .addr(addr), .card_id(card_id), .dec(dec)
  );

  assign start    = (state == ST_IDLE) && dec.hit && (rd_rise || wr_rise);
  assign start_rd = start && rd_rise;
  assign start_wr = start && !rd_rise;
  assign held     = cyc_rd ? rd_lvl : wr_lvl;

  always_comb begin
    port_hot = '0;
    if (dec.port_sel) port_hot[dec.port] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (dec.port_sel) begin
      if (dec.is_data) rd_mux = ch_rx_i[dec.port*DW +: DW];
      else             rd_mux = ch_stat_i[dec.port*DW +: DW];
    end
  end

  qcr_cardregs #(.DW(DW), .LVL_W(LVL_W), .DIV_INIT(DIV_INIT)) i_regs (
    .clk(clk), .rst(rst),
    .wr_en(start_wr && !dec.port_sel),
    .off(dec.off), .wdata(dbus_in),
    .rts_mask(rts_mask), .irq_level(irq_level), .baud_div(baud_div),
    .swtx_irq(swtx_irq), .irq_off(irq_off), .irq_on(irq_on),
    .chan_rst(chan_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cyc_rd     <= 1'b0;
      apre       <= 1'b0;
      drdy       <= 1'b0;
      dbus_oe    <= 1'b0;
      dbus_out   <= '0;
      wr_byte    <= '0;
      ctl_wr_stb <= '0;
      tx_wr_stb  <= '0;
      rx_rd_stb  <= '0;
    end else begin
      ctl_wr_stb <= '0;
      tx_wr_stb  <= '0;
      rx_rd_stb  <= '0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_PRE;
            apre   <= 1'b1;
            cyc_rd <= start_rd;
            if (start_rd) begin
              dbus_oe  <= 1'b1;
              dbus_out <= rd_mux;
              if (dec.is_data) rx_rd_stb <= port_hot;
            end else begin
              wr_byte <= dbus_in;
              if (dec.is_data) tx_wr_stb  <= port_hot;
              else             ctl_wr_stb <= port_hot;
            end
          end
        end
        ST_PRE: begin
          state <= ST_RDY;
          drdy  <= 1'b1;
        end
        ST_RDY: begin
          if (!held) begin
            state    <= ST_IDLE;
            apre     <= 1'b0;
            drdy     <= 1'b0;
            dbus_oe  <= 1'b0;
            dbus_out <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qcr_regfront_chk.sv
module qcr_regfront_chk #(
  parameter int NP    = 4,
  parameter int LVL_W = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          apre,
  input logic          drdy,
  input logic          dbus_oe,
  input logic [NP-1:0] ctl_wr_stb,
  input logic [NP-1:0] tx_wr_stb,
  input logic [NP-1:0] rx_rd_stb,
  input logic [NP-1:0] rts_mask,
  input logic [LVL_W-1:0] irq_level,
  input logic          swtx_irq,
  input logic          irq_off,
  input logic          irq_on,
  input logic          chan_rst
);
  logic any_pulse;
  assign any_pulse = (|ctl_wr_stb) | (|tx_wr_stb) | (|rx_rd_stb) |
                     swtx_irq | irq_off | irq_on | chan_rst;

  p_drdy_inside_apre_r2: assert property (@(posedge clk) disable iff (rst)
    drdy |-> apre);

  p_drdy_follows_apre_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(apre) |=> (apre && drdy));

  p_pulse_at_apre_rise_r4: assert property (@(posedge clk) disable iff (rst)
    any_pulse |-> (apre && !$past(apre)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    any_pulse |=> !any_pulse);

  p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_wr_stb, tx_wr_stb, rx_rd_stb, swtx_irq, irq_off, irq_on, chan_rst}));

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    chan_rst |-> (rts_mask == '0 && irq_level == '0));

  p_drive_in_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> apre);
endmodule

bind qcr_regfront qcr_regfront_chk #(.NP(qcr_pkg::NUM_PORTS), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rst(rst), .apre(apre), .drdy(drdy), .dbus_oe(dbus_oe),
  .ctl_wr_stb(ctl_wr_stb), .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb),
  .rts_mask(rts_mask), .irq_level(irq_level),
  .swtx_irq(swtx_irq), .irq_off(irq_off), .irq_on(irq_on), .chan_rst(chan_rst)
);

// File: tb/test_qcr_regfront.sv
module test_qcr_regfront;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  card_id = 4'h3;
  logic [15:0] addr = '0;
  logic [7:0]  dbus_in = '0;
  logic        rd_req = 1'b0;
  logic        wr_req = 1'b0;
  logic [31:0] ch_stat_i = {8'h43, 8'h42, 8'h41, 8'h40};
  logic [31:0] ch_rx_i   = {8'h93, 8'h92, 8'h91, 8'h90};
  logic [7:0]  dbus_out;
  logic        dbus_oe, apre, drdy;
  logic [3:0]  ctl_wr_stb, tx_wr_stb, rx_rd_stb;
  logic [7:0]  wr_byte;
  logic [3:0]  rts_mask, irq_level;
  logic [7:0]  baud_div;
  logic        swtx_irq, irq_off, irq_on, chan_rst;

  always #2.5 clk = ~clk;

  qcr_regfront i_qcr_regfront (
    .clk(clk), .rst(rst), .card_id(card_id), .addr(addr), .dbus_in(dbus_in),
    .rd_req(rd_req), .wr_req(wr_req), .ch_stat_i(ch_stat_i), .ch_rx_i(ch_rx_i),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .apre(apre), .drdy(drdy),
    .ctl_wr_stb(ctl_wr_stb), .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb),
    .wr_byte(wr_byte), .rts_mask(rts_mask), .irq_level(irq_level),
    .baud_div(baud_div), .swtx_irq(swtx_irq), .irq_off(irq_off),
    .irq_on(irq_on), .chan_rst(chan_rst)
  );

  int n_chk = 0;
  int n_bad = 0;

  // snapshots: a_* in the apre-rise cycle, d_* in the drdy cycle
  logic        hs_ok, a_doe;
  logic [3:0]  a_ctl, a_tx, a_rx, a_cmd;
  logic [7:0]  d_dout;
  logic        d_doe, d_quiet;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic [15:0] a, input logic [7:0] d);
    logic pre_ok, a_ok, d_ok, hold_ok, rel_ok;
    @(negedge clk);
    addr = a; dbus_in = d; rd_req = rd; wr_req = !rd;
    repeat (2) @(negedge clk);
    pre_ok = !apre;
    @(negedge clk);
    a_ok  = apre && !drdy;
    a_doe = dbus_oe;
    a_ctl = ctl_wr_stb; a_tx = tx_wr_stb; a_rx = rx_rd_stb;
    a_cmd = {swtx_irq, irq_off, irq_on, chan_rst};
    @(negedge clk);
    d_ok    = apre && drdy;
    d_dout  = dbus_out;
    d_doe   = dbus_oe;
    d_quiet = (ctl_wr_stb == 0) && (tx_wr_stb == 0) && (rx_rd_stb == 0) &&
              !swtx_irq && !irq_off && !irq_on && !chan_rst;
    rd_req = 1'b0; wr_req = 1'b0;
    repeat (2) @(negedge clk);
    hold_ok = apre && drdy;
    @(negedge clk);
    rel_ok = !apre && !drdy && !dbus_oe && (dbus_out == 8'h00);
    hs_ok = pre_ok && a_ok && d_ok && hold_ok && rel_ok;
  endtask

  task automatic t_reset;
    chk(!apre && !drdy && !dbus_oe && dbus_out == 0, "R11 bus idle", {apre, drdy, dbus_oe}, 0);
    chk(rts_mask == 0 && irq_level == 0 && wr_byte == 0, "R11 regs", {rts_mask, irq_level}, 0);
    chk(baud_div == 8'hFE, "R11 divisor", baud_div, 8'hFE);
  endtask

  task automatic t_port_reads;
    for (int p = 0; p < 4; p++) begin
      xfer(1'b1, {8'hF2, 4'h3, 4'(2*p)}, 8'h00);
      chk(hs_ok, "R2 read handshake", hs_ok, 1);
      chk(d_doe && d_dout == 8'(8'h40 + p), "R3 status read", d_dout, 8'h40 + p);
      chk(a_rx == 0, "R4 no rx strobe on status", a_rx, 0);
      xfer(1'b1, {8'hF2, 4'h3, 4'(2*p+1)}, 8'h00);
      chk(d_doe && d_dout == 8'(8'h90 + p), "R3 data read", d_dout, 8'h90 + p);
      chk(a_rx == 4'(1 << p) && d_quiet, "R4 rx strobe once", a_rx, 1 << p);
    end
  endtask

  task automatic t_port_writes;
    xfer(1'b0, 16'hF232, 8'hC5);
    chk(hs_ok, "R2 write handshake", hs_ok, 1);
    chk(a_ctl == 4'b0010 && a_tx == 0 && d_quiet, "R5 ctl strobe", a_ctl, 4'b0010);
    chk(wr_byte == 8'hC5, "R5 write byte", wr_byte, 8'hC5);
    chk(!a_doe && !d_doe, "R10 no drive on write", {a_doe, d_doe}, 0);
    xfer(1'b0, 16'hF237, 8'h5A);
    chk(a_tx == 4'b1000 && a_ctl == 0 && d_quiet, "R5 tx strobe", a_tx, 4'b1000);
    chk(wr_byte == 8'h5A, "R5 write byte 2", wr_byte, 8'h5A);
  endtask

  task automatic t_card_regs;
    xfer(1'b0, 16'hF238, 8'hFA);
    chk(rts_mask == 4'hA, "R6 rts mask", rts_mask, 4'hA);
    xfer(1'b0, 16'hF23A, 8'h05);
    chk(irq_level == 4'h5, "R6 irq level", irq_level, 4'h5);
    xfer(1'b0, 16'hF23B, 8'h37);
    chk(baud_div == 8'h37, "R6 divisor", baud_div, 8'h37);
    xfer(1'b0, 16'hF239, 8'hFF);
    chk(a_cmd == 0 && a_ctl == 0 && a_tx == 0 && rts_mask == 4'hA &&
        irq_level == 4'h5 && baud_div == 8'h37, "R9 offset 9 inert", a_cmd, 0);
  endtask

  task automatic t_commands;
    xfer(1'b0, 16'hF23C, 8'h00);
    chk(a_cmd == 4'b1000 && d_quiet, "R7 swtx pulse", a_cmd, 4'b1000);
    xfer(1'b0, 16'hF23D, 8'h00);
    chk(a_cmd == 4'b0100 && d_quiet, "R7 irq off pulse", a_cmd, 4'b0100);
    xfer(1'b0, 16'hF23E, 8'h00);
    chk(a_cmd == 4'b0010 && d_quiet, "R7 irq on pulse", a_cmd, 4'b0010);
    xfer(1'b0, 16'hF23F, 8'h00);
    chk(a_cmd == 4'b0001 && d_quiet, "R8 reset pulse", a_cmd, 4'b0001);
    chk(rts_mask == 0 && irq_level == 0, "R8 regs cleared", {rts_mask, irq_level}, 0);
    chk(baud_div == 8'h37, "R8 divisor kept", baud_div, 8'h37);
  endtask

  task automatic t_wo_reads;
    for (int o = 8; o < 16; o++) begin
      xfer(1'b1, {8'hF2, 4'h3, 4'(o)}, 8'h00);
      chk(hs_ok && d_doe && d_dout == 8'h00, "R9 write-only read", d_dout, 0);
    end
  endtask

  task automatic t_unselected;
    logic seen;
    seen = 1'b0;
    @(negedge clk);
    addr = 16'hF251; rd_req = 1'b1;
    repeat (8) @(negedge clk) seen |= apre | drdy | dbus_oe | (|rx_rd_stb);
    rd_req = 1'b0;
    repeat (4) @(negedge clk);
    addr = 16'hF331; wr_req = 1'b1;
    repeat (8) @(negedge clk) seen |= apre | drdy | dbus_oe | (|tx_wr_stb);
    wr_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(!seen, "R1 other card ignored", seen, 0);
    card_id = 4'h5;
    xfer(1'b1, 16'hF251, 8'h00);
    chk(hs_ok && d_dout == 8'h90 && a_rx == 4'b0001, "R1 new card id", d_dout, 8'h90);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_port_reads;
    t_port_writes;
    t_card_regs;
    t_commands;
    t_wo_reads;
    t_unselected;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule